// File: doc/BRIEF.md
# Scanline-Prescaled Interrupt Timer

This block is an interrupt timer for a memory-mapper style cartridge controller. An 8-bit counter counts upward from a reload value. Each time it passes 0xFF it loads the reload value again and raises a level interrupt request. The counter is advanced by one of two sources. In cycle mode it advances on every CPU cycle. In scanline mode a prescaler budget of 341 is reduced by 3 on each CPU cycle, which gives one advance per 113⅔ CPU cycles on average, about one per video line.

Software drives the block through a write strobe, a 3-bit operation code and a data byte. It can load the reload value, write the mode, or acknowledge the interrupt. The `SPLIT_LATCH` parameter picks the reload-write variant. When it is 0, the whole byte is loaded by one operation. When it is 1, the byte is loaded as two separate nibble operations. The CPU-cycle strobe `cpu_tick` is a clock enable. The asynchronous active-low reset is expected to be released synchronously to `clk` by the surrounding logic.

Top module: `irqtmr_scanline`

## Requirements
- R1: While `rst_n` is low, `irq` is 0. Reset clears the reload value, the mode, the counter and the prescaler to 0.
- R2: With `SPLIT_LATCH`=0, operation code 0 loads the whole reload value from `wr_data`. Operation codes 1 and 2 have no effect.
- R3: With `SPLIT_LATCH`=1, operation code 1 loads reload bits [3:0] from `wr_data[3:0]` and operation code 2 loads reload bits [7:4] from `wr_data[3:0]`. Operation code 0 has no effect.
- R4: Operation code 3 writes the mode from `wr_data[2:0]`, where bit 0 is re-arm, bit 1 is run and bit 2 is cycle mode, and it clears `irq`. When `wr_data[1]` is 1, the same write loads the counter from the reload value and sets the prescaler to 341.
- R5: Operation code 4 (acknowledge) clears `irq` and copies mode bit 0 into mode bit 1. Bits 0 and 2 are left as they were.
- R6: With run and cycle mode both set, every counted CPU cycle advances the counter by one step.
- R7: With run set and cycle mode clear, every counted CPU cycle subtracts 3 from the prescaler. If the result is 0 or less, the counter advances and 341 is added to that result. Starting from a fresh 341, the first advance therefore falls on the 114th counted cycle.
- R8: An advance from 0xFF loads the counter from the reload value and sets `irq`. Any other advance increments the counter. With a reload value of 0x00 in cycle mode, an interrupt occurs every 256 cycles.
- R9: Once set, `irq` stays high until an operation code 3 or 4 write.
- R10: While run is clear, the counter and the prescaler hold and `irq` does not rise.
- R11: A cycle with `wr_en` high is never counted, whatever the operation code. Operation codes 5 to 7 have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tick | input | 1 | One CPU cycle has elapsed |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 3 | Operation code of the write |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `wr_op` and `wr_data` are stable whenever `wr_en` is high. They also assume that `cpu_tick` carries no meaning of its own in a write cycle. The bench drives every input on the falling edge, so each write and each tick is seen by exactly one rising edge. The stimulus deliberately raises `cpu_tick` together with writes, including writes that use unused operation codes, to show that such cycles are dropped. Two instances, one per reload-write variant, receive identical stimulus.

// File: rtl/irqtmr_pkg.sv
package irqtmr_pkg;

  typedef enum logic [2:0] {
    OP_RELOAD_ALL = 3'd0,
    OP_RELOAD_LO  = 3'd1,
    OP_RELOAD_HI  = 3'd2,
    OP_MODE       = 3'd3,
    OP_ACK        = 3'd4
  } irq_op_e;

  typedef struct packed {
    logic cyc;
    logic run;
    logic rearm;
  } mode_t;

  localparam int MODE_W = 3;

endpackage

// File: rtl/irqtmr_regs.sv
module irqtmr_regs
  import irqtmr_pkg::*;
#(
  parameter int DW    = 8,
  parameter bit SPLIT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lo_wr_i,
  input  logic          hi_wr_i,
  input  logic          mode_wr_i,
  input  logic          ack_wr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] reload_o,
  output mode_t         mode_o
);

  localparam int HW = DW / 2;

  logic [DW-1:0] reload_q, reload_d;
  logic [HW-1:0] hi_src;
  mode_t         mode_q, mode_d;

  generate
    if (SPLIT) begin : g_nibble
      logic data_top_unused;
      assign data_top_unused = ^data_i[DW-1:HW];
      assign hi_src = data_i[HW-1:0];
    end else begin : g_whole
      assign hi_src = data_i[DW-1:HW];
    end
  endgenerate

  always_comb begin
    reload_d = reload_q;
    if (lo_wr_i) reload_d[HW-1:0]  = data_i[HW-1:0];
    if (hi_wr_i) reload_d[DW-1:HW] = hi_src;
  end

  always_comb begin
    mode_d = mode_q;
    if (mode_wr_i) begin
      mode_d = mode_t'(data_i[MODE_W-1:0]);
    end else if (ack_wr_i) begin
      mode_d.run = mode_q.rearm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      mode_q   <= '0;
    end else begin
      if (lo_wr_i || hi_wr_i)      reload_q <= reload_d;
      if (mode_wr_i || ack_wr_i)   mode_q   <= mode_d;
    end
  end

  assign reload_o = reload_q;
  assign mode_o   = mode_q;

  // R5
  ack_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr_i && !mode_wr_i) |=> (mode_q.run == $past(mode_q.rearm)) &&
                                  (mode_q.rearm == $past(mode_q.rearm)) &&
                                  (mode_q.cyc == $past(mode_q.cyc)));

  // R4
  mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_i |=> (mode_q == $past(data_i[MODE_W-1:0])));

  // R2
  reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_wr_i && !hi_wr_i) |=> $stable(reload_q));

endmodule

// File: rtl/irqtmr_prescale.sv
module irqtmr_prescale #(
  parameter int PS_W   = 10,
  parameter int BUDGET = 341,
  parameter int STEP   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic cyc_i,
  input  logic reload_i,
  output logic tick_o
);

  localparam logic signed [PS_W-1:0] PS_FULL = PS_W'(BUDGET);
  localparam logic signed [PS_W-1:0] PS_DEC  = PS_W'(STEP);

  logic signed [PS_W-1:0] ps_q, ps_d, ps_sub;
  logic                   ps_en;
  logic                   tick;

  assign ps_sub = ps_q - PS_DEC;

  always_comb begin
    ps_d  = ps_q;
    ps_en = 1'b0;
    tick  = 1'b0;
    if (reload_i) begin
      ps_d  = PS_FULL;
      ps_en = 1'b1;
    end else if (step_i) begin
      if (cyc_i) begin
        tick = 1'b1;
      end else begin
        ps_en = 1'b1;
        if (ps_sub <= 0) begin
          tick = 1'b1;
          ps_d = ps_sub + PS_FULL;
        end else begin
          ps_d = ps_sub;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= '0;
    end else if (ps_en) begin
      ps_q <= ps_d;
    end
  end

  assign tick_o = tick;

  // R7
  ps_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_q >= 0) && (ps_q <= PS_FULL));

  // R10
  ps_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !reload_i) |=> $stable(ps_q));

endmodule

// File: rtl/irqtmr_count.sv
module irqtmr_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             irq_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             wrap;

  assign wrap = tick_i && (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i || wrap) begin
      cnt_d = reload_i;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (clr_i)     irq_d = 1'b0;
    else if (wrap) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (load_i || tick_i) cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(tick_i && (&cnt_q)));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr_i) |=> irq_q);

  // R4
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !irq_q);

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/irqtmr_scanline.sv
module irqtmr_scanline
  import irqtmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PS_W        = 10,
  parameter int PS_BUDGET   = 341,
  parameter int PS_STEP     = 3,
  parameter bit SPLIT_LATCH = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_tick,
  input  logic             wr_en,
  input  logic [2:0]       wr_op,
  input  logic [CNT_W-1:0] wr_data,
  output logic             irq
);

  logic  lo_wr, hi_wr, mode_wr, ack_wr;
  logic  count_cycle, tick, load;
  logic [CNT_W-1:0] reload;
  mode_t mode;

  generate
    if (SPLIT_LATCH) begin : g_dec_nibble
      assign lo_wr = wr_en && (wr_op == OP_RELOAD_LO);
      assign hi_wr = wr_en && (wr_op == OP_RELOAD_HI);
    end else begin : g_dec_whole
      assign lo_wr = wr_en && (wr_op == OP_RELOAD_ALL);
      assign hi_wr = lo_wr;
    end
  endgenerate

  assign mode_wr     = wr_en && (wr_op == OP_MODE);
  assign ack_wr      = wr_en && (wr_op == OP_ACK);
  assign count_cycle = cpu_tick && !wr_en && mode.run;
  assign load        = mode_wr && wr_data[1];

  irqtmr_regs #(
    .DW    (CNT_W),
    .SPLIT (SPLIT_LATCH)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_wr_i   (lo_wr),
    .hi_wr_i   (hi_wr),
    .mode_wr_i (mode_wr),
    .ack_wr_i  (ack_wr),
    .data_i    (wr_data),
    .reload_o  (reload),
    .mode_o    (mode)
  );

  irqtmr_prescale #(
    .PS_W   (PS_W),
    .BUDGET (PS_BUDGET),
    .STEP   (PS_STEP)
  ) u_prescale (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (count_cycle),
    .cyc_i    (mode.cyc),
    .reload_i (load),
    .tick_o   (tick)
  );

  irqtmr_count #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .load_i   (load),
    .clr_i    (mode_wr || ack_wr),
    .reload_i (reload),
    .irq_o    (irq)
  );

  // R11
  write_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !tick);

  // R6
  cyc_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_tick && !wr_en && mode.run && mode.cyc) |-> tick);

endmodule

// File: tb/test_irqtmr_scanline.sv
module test_irqtmr_scanline;

  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_op = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic       irq_w, irq_s;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int m_lat  [2];
  int m_mode [2];
  int m_cnt  [2];
  int m_ps   [2];
  bit m_irq  [2];

  always #(CLK_NS/2) clk = ~clk;

  irqtmr_scanline #(.SPLIT_LATCH(1'b0)) i_irqtmr_scanline (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_en(wr_en),
    .wr_op(wr_op), .wr_data(wr_data), .irq(irq_w)
  );

  irqtmr_scanline #(.SPLIT_LATCH(1'b1)) i_irqtmr_scanline_split (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_en(wr_en),
    .wr_op(wr_op), .wr_data(wr_data), .irq(irq_s)
  );

  // Behavioural reference: index 0 whole-byte reload, index 1 nibble reload.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < 2; v++) begin
        m_lat[v] = 0; m_mode[v] = 0; m_cnt[v] = 0; m_ps[v] = 0; m_irq[v] = 0;
      end
    end else begin
      for (int v = 0; v < 2; v++) begin
        bit fire;
        fire = 0;
        if (wr_en) begin
          case (wr_op)
            3'd0: if (v == 0) m_lat[v] = wr_data;
            3'd1: if (v == 1) m_lat[v] = (m_lat[v] & 'hF0) | (wr_data & 'h0F);
            3'd2: if (v == 1) m_lat[v] = (m_lat[v] & 'h0F) | ((wr_data & 'h0F) << 4);
            3'd3: begin
              m_mode[v] = wr_data & 7;
              m_irq[v]  = 0;
              if ((wr_data & 2) != 0) begin
                m_cnt[v] = m_lat[v];
                m_ps[v]  = 341;
              end
            end
            3'd4: begin
              m_irq[v]  = 0;
              m_mode[v] = (m_mode[v] & 5) | ((m_mode[v] & 1) << 1);
            end
            default: ;
          endcase
        end else if (cpu_tick && ((m_mode[v] & 2) != 0)) begin
          if ((m_mode[v] & 4) != 0) begin
            fire = 1;
          end else begin
            m_ps[v] = m_ps[v] - 3;
            if (m_ps[v] <= 0) begin
              fire = 1;
              m_ps[v] = m_ps[v] + 341;
            end
          end
          if (fire) begin
            if (m_cnt[v] == 255) begin
              m_cnt[v] = m_lat[v];
              m_irq[v] = 1;
            end else begin
              m_cnt[v] = m_cnt[v] + 1;
            end
          end
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit w, input int op, input int d, input bit t);
    wr_en    = w;
    wr_op    = op[2:0];
    wr_data  = d[7:0];
    cpu_tick = t;
    @(posedge clk);
    @(negedge clk);
    check("R6 R7 R8 R9 R11 model irq whole", int'(irq_w), int'(m_irq[0]));
    check("R6 R7 R8 R9 R11 model irq split", int'(irq_s), int'(m_irq[1]));
  endtask

  task automatic run_until(input int maxn, output int na, output int nb);
    na = -1;
    nb = -1;
    for (int n = 1; n <= maxn && (na < 0 || nb < 0); n++) begin
      cyc(0, 0, 0, 1);
      if (na < 0 && irq_w) na = n;
      if (nb < 0 && irq_s) nb = n;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int na, nb;
    #1;
    check("R1 reset irq whole", int'(irq_w), 0);
    check("R1 reset irq split", int'(irq_s), 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0);

    // R10: mode 0 after reset, ticks have no effect
    for (int i = 0; i < 300; i++) cyc(0, 0, 0, 1);
    check("R10 idle irq whole", int'(irq_w), 0);

    // R2 / R3: reload writes per variant, then cycle mode
    cyc(1, 0, 'hF0, 0);
    cyc(1, 1, 'h0A, 0);
    cyc(1, 2, 'h0C, 0);
    cyc(1, 3, 'h06, 0);
    run_until(300, na, nb);
    check("R2 whole reload F0 irq after 16", na, 16);
    check("R3 nibble reload CA irq after 54", nb, 54);

    // R9: irq stays high while counting continues
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1);
    check("R9 irq held whole", int'(irq_w), 1);
    check("R9 irq held split", int'(irq_s), 1);

    // R5: ack with re-arm 0 clears irq and stops
    cyc(1, 4, 'hFF, 0);
    check("R5 ack clears irq whole", int'(irq_w), 0);
    check("R5 ack clears irq split", int'(irq_s), 0);
    for (int i = 0; i < 400; i++) cyc(0, 0, 0, 1);
    check("R10 stopped after ack whole", int'(irq_w), 0);
    check("R10 stopped after ack split", int'(irq_s), 0);

    // R4: mode write with run reloads; re-arm keeps running after ack
    cyc(1, 3, 'h07, 0);
    run_until(300, na, nb);
    check("R4 reload on mode write whole", na, 16);
    check("R4 reload on mode write split", nb, 54);
    cyc(1, 4, 0, 0);
    run_until(300, na, nb);
    check("R5 re-arm continues whole", na, 10);
    check("R5 re-arm continues split", nb, 54);

    // R11: write cycles with cpu_tick are not counted
    cyc(1, 3, 'h06, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1);
    for (int i = 0; i < 4; i++) cyc(1, 5, 'hFF, 1);
    run_until(300, na, nb);
    check("R11 dropped cycles whole", na, 8);
    check("R11 dropped cycles split", nb, 46);

    // R7: scanline prescaler intervals 114, 114, 113
    cyc(1, 0, 'hFF, 0);
    cyc(1, 1, 'h0F, 0);
    cyc(1, 2, 'h0F, 0);
    cyc(1, 3, 'h03, 0);
    run_until(400, na, nb);
    check("R7 first scanline tick whole", na, 114);
    check("R7 first scanline tick split", nb, 114);
    cyc(1, 4, 0, 0);
    run_until(400, na, nb);
    check("R7 second scanline tick", na, 114);
    cyc(1, 4, 0, 0);
    run_until(400, na, nb);
    check("R7 third scanline tick", na, 113);

    // R8: reload 0x00 gives 256 cycles per interrupt
    cyc(1, 0, 'h00, 0);
    cyc(1, 1, 'h00, 0);
    cyc(1, 2, 'h00, 0);
    cyc(1, 3, 'h06, 0);
    run_until(400, na, nb);
    check("R8 wrap period whole", na, 256);
    check("R8 wrap period split", nb, 256);

    // Mixed stimulus against the reference model
    for (int i = 0; i < 4000; i++) begin
      bit w;
      w = ($urandom_range(15) == 0);
      cyc(w, int'($urandom_range(7)), int'($urandom_range(255)), ($urandom_range(3) != 0));
    end

    // R1: reset in the middle of operation
    cyc(1, 0, 'hFE, 0);
    cyc(1, 3, 'h06, 0);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    check("R8 irq before reset", int'(irq_w), 1);
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset irq whole", int'(irq_w), 0);
    check("R1 mid-run reset irq split", int'(irq_s), 0);
    finish_run();
  end

endmodule